// File: doc/BRIEF.md
# Register-Mapped CRC-16 Calculator

This block computes a 16-bit CRC over a stream of bytes that software feeds to it one register write at a time. Software first clears the engine by writing the clear bit of the control register. It then writes each data item to the input register. At any point it can read the number of items absorbed and the running CRC. The polynomial is x^16+x^12+x^5+1 and bits are taken least-significant first. The remainder is preset to all ones, and the result register returns the bitwise inverse of the remainder. With these conventions the engine meets a fixed start-up self-test vector.

The register port is a plain single-cycle interface. A write is taken on every clock edge where `reg_wr` is high, and the port never applies back-pressure. Read data is combinational from `reg_addr`. A read in the cycle after a write therefore already sees the effect of that write.

Top module: `crc_reg_engine`

## Requirements
- R1: After the asynchronous reset, the control register reads 0x0000, the result register (address 3) reads 0x0000, and the remainder register (address 2) reads 0xFFFF.
- R2: A write to the control register (address 0) with bit 15 set returns the remainder to 0xFFFF and the item count to 0. Bit 15 always reads back as 0.
- R3: A write to the control register with bit 15 clear changes neither the count nor the CRC.
- R4: Each write to the input register (address 1) folds bits 7:0 of the write data into the CRC and counts as one item. Bits 15:8 of that write have no effect on the CRC.
- R5: Control register bits 11:0 read back the item count since the last clear. Bits 15:12 read as 0.
- R6: The item count saturates at 0xFFF. Further input writes leave it at 0xFFF and still update the CRC.
- R7: After a clear followed by input writes of 0xCC, 0xF5, 0xF1 and 0xA7, the count reads 4 and the result register reads 0x51DF.
- R8: The result register always reads the bitwise inverse of the remainder register.
- R9: Writes to the remainder register (address 2) and to the result register are ignored.
- R10: A byte written on one clock edge is fully folded by the next read cycle. The CRC is updated one byte per clock, with no wait states.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Write strobe, one register write per cycle |
| reg_addr | input | 2 | Register select: 0 control/count, 1 input, 2 remainder, 3 result |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the register selected by reg_addr |

## Verification
The bench targets the self-test vector. A wrong bit order, preset or output inversion shows up at once as a result other than 0x51DF. It writes the same low byte with different upper bits; a design that folded the upper bits would give two different CRCs. It drives the count past 4095, where a wrapping counter would read 0 again. It also issues control writes without the clear bit and writes to the read-only registers; a design that decoded these loosely would lose or corrupt its running state.

// File: rtl/crc_regs_pkg.sv
package crc_regs_pkg;

  typedef enum logic [1:0] {
    RA_CTRL   = 2'd0,
    RA_DATA   = 2'd1,
    RA_REMAIN = 2'd2,
    RA_RESULT = 2'd3
  } reg_addr_e;

  localparam int unsigned CTRL_CLR_BIT = 15;

endpackage

// File: rtl/crc_byte_step.sv
module crc_byte_step #(
  parameter int unsigned CRC_W  = 16,
  parameter int unsigned BYTE_W = 8,
  parameter logic [CRC_W-1:0] POLY_REFL = 16'h8408
) (
  input  logic [CRC_W-1:0]  crc_in,
  input  logic [BYTE_W-1:0] byte_in,
  output logic [CRC_W-1:0]  crc_out
);

  logic [CRC_W-1:0] stage [BYTE_W+1];

  assign stage[0] = crc_in;

  // One shift-and-conditional-xor per data bit, LSB first.
  for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
    logic fb;
    assign fb = stage[i][0] ^ byte_in[i];
    assign stage[i+1] = fb ? ((stage[i] >> 1) ^ POLY_REFL) : (stage[i] >> 1);
  end

  assign crc_out = stage[BYTE_W];

endmodule

// File: rtl/crc_item_counter.sv
module crc_item_counter #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (clr) begin
      count <= '0;
    end else if (inc && (count != CNT_MAX)) begin
      count <= count + 1'b1;
    end
  end

endmodule

// File: rtl/crc_reg_engine.sv
module crc_reg_engine #(
  parameter int unsigned REG_W  = 16,
  parameter int unsigned CRC_W  = 16,
  parameter int unsigned CNT_W  = 12,
  parameter int unsigned IN_W   = 12,
  parameter int unsigned BYTE_W = 8,
  parameter logic [CRC_W-1:0] POLY_REFL = 16'h8408,
  parameter logic [CRC_W-1:0] PRESET    = 16'hFFFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata
);
  import crc_regs_pkg::*;

  localparam int unsigned CTRL_PAD = REG_W - CNT_W;

  logic             clr_req;
  logic             data_wr;
  logic [IN_W-1:0]  data_masked;
  logic [CRC_W-1:0] remainder;
  logic [CRC_W-1:0] remainder_nxt;
  logic [CRC_W-1:0] crc_result;
  logic [CNT_W-1:0] item_count;

  assign clr_req     = reg_wr && (reg_addr == RA_CTRL) && reg_wdata[CTRL_CLR_BIT];
  assign data_wr     = reg_wr && (reg_addr == RA_DATA);
  assign data_masked = reg_wdata[IN_W-1:0];

  crc_byte_step #(
    .CRC_W    (CRC_W),
    .BYTE_W   (BYTE_W),
    .POLY_REFL(POLY_REFL)
  ) u_step (
    .crc_in (remainder),
    .byte_in(data_masked[BYTE_W-1:0]),
    .crc_out(remainder_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remainder <= PRESET;
    end else if (clr_req) begin
      remainder <= PRESET;
    end else if (data_wr) begin
      remainder <= remainder_nxt;
    end
  end

  crc_item_counter #(
    .CNT_W(CNT_W)
  ) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (clr_req),
    .inc  (data_wr),
    .count(item_count)
  );

  assign crc_result = ~remainder;

  always_comb begin
    case (reg_addr)
      RA_CTRL:   reg_rdata = {{CTRL_PAD{1'b0}}, item_count};
      RA_REMAIN: reg_rdata = remainder;
      RA_RESULT: reg_rdata = crc_result;
      default:   reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/crc_reg_engine_chk.sv
module crc_reg_engine_chk #(
  parameter int unsigned CNT_W = 12,
  parameter int unsigned CRC_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [1:0]       reg_addr,
  input logic [15:0]      reg_wdata,
  input logic [CNT_W-1:0] count,
  input logic [CRC_W-1:0] crc_out
);

  localparam logic [CNT_W-1:0] CMAX = '1;

  // R2
  a_r2_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd0 && reg_wdata[15]) |=> (count == '0 && crc_out == '0));

  // R3
  a_r3_ctrl_noop: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd0 && !reg_wdata[15]) |=> ($stable(count) && $stable(crc_out)));

  // R4
  a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd1 && count != CMAX) |=> (count == $past(count) + 1'b1));

  // R6
  a_r6_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd1 && count == CMAX) |=> (count == CMAX));

  // R9
  a_r9_ro_regs: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr[1]) |=> ($stable(count) && $stable(crc_out)));

endmodule

bind crc_reg_engine crc_reg_engine_chk #(
  .CNT_W(CNT_W),
  .CRC_W(CRC_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_wr   (reg_wr),
  .reg_addr (reg_addr),
  .reg_wdata(reg_wdata),
  .count    (item_count),
  .crc_out  (crc_result)
);

// File: tb/sim_crc_reg_engine.sv
module sim_crc_reg_engine;

  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  logic [15:0] q_exp [$];
  string       q_tag [$];

  logic [15:0] m_rem = 16'hFFFF;
  int          m_cnt = 0;

  crc_reg_engine u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] ref_fold(logic [15:0] r, logic [7:0] b);
    logic [15:0] x = r ^ {8'h00, b};
    for (int k = 0; k < 8; k++) begin
      if (x[0]) x = (x >> 1) ^ 16'h8408;
      else      x = x >> 1;
    end
    return x;
  endfunction

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    if (a == 2'd0 && d[15]) begin
      m_rem = 16'hFFFF; m_cnt = 0;
    end else if (a == 2'd1) begin
      m_rem = ref_fold(m_rem, d[7:0]);
      if (m_cnt < 4095) m_cnt++;
    end
  endtask

  task automatic rd(input logic [1:0] a, input logic [15:0] exp, input string tag);
    @(posedge clk); #1;
    reg_wr = 1'b0; reg_addr = a;
    q_exp.push_back(exp);
    q_tag.push_back(tag);
  endtask

  // Monitor: compares each queued expectation against the read port.
  always @(negedge clk) begin
    if (q_exp.size() != 0) begin
      logic [15:0] e;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      checks++;
      if (reg_rdata !== e) begin
        errors++;
        $display("FAIL %s: got 0x%04h expected 0x%04h", t, reg_rdata, e);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (!done && cycles > WATCHDOG) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got %0d cycles expected at most %0d", cycles, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] save_res;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(2'd0, 16'h0000, "R1 ctrl after reset");
    rd(2'd3, 16'h0000, "R1 result after reset");
    rd(2'd2, 16'hFFFF, "R1 remainder after reset");

    // R7 self-test vector, R2 clear bit reads 0
    wr(2'd0, 16'h8000);
    wr(2'd1, 16'h00CC);
    wr(2'd1, 16'h00F5);
    wr(2'd1, 16'h00F1);
    wr(2'd1, 16'h00A7);
    rd(2'd0, 16'h0004, "R7 count after vector (R2 bit15 reads 0)");
    rd(2'd3, 16'h51DF, "R7 result after vector");
    rd(2'd2, 16'hAE20, "R8 remainder is inverse of result");

    // R10 read right after a single write
    wr(2'd1, 16'h0033);
    rd(2'd3, ~m_rem, "R10 result one cycle after write");

    // R3 control write without clear bit
    save_res = ~m_rem;
    wr(2'd0, 16'h7FFF);
    rd(2'd0, 16'h0005, "R3 count unchanged");
    rd(2'd3, save_res, "R3 result unchanged");

    // R9 writes to read-only registers
    wr(2'd2, 16'h1234);
    wr(2'd3, 16'hABCD);
    rd(2'd2, m_rem, "R9 remainder unchanged");
    rd(2'd0, 16'h0005, "R9 count unchanged");

    // R4 upper bits ignored
    wr(2'd0, 16'h8000);
    wr(2'd1, 16'h005A);
    save_res = ~m_rem;
    rd(2'd3, save_res, "R4 result low byte only");
    wr(2'd0, 16'h8000);
    wr(2'd1, 16'hFF5A);
    rd(2'd3, save_res, "R4 upper bits ignored");
    rd(2'd0, 16'h0001, "R4 one item counted");

    // R2 clear mid-stream
    wr(2'd1, 16'h0011);
    wr(2'd0, 16'h8000);
    rd(2'd0, 16'h0000, "R2 count cleared");
    rd(2'd3, 16'h0000, "R2 result cleared");

    // R6 / R5 saturation
    for (int n = 0; n < 4095; n++) wr(2'd1, 16'(n));
    rd(2'd0, 16'h0FFF, "R5 count at max, top bits zero");
    wr(2'd1, 16'h0042);
    wr(2'd1, 16'h0099);
    rd(2'd0, 16'h0FFF, "R6 count saturated");
    rd(2'd3, ~m_rem, "R6 CRC still updates at saturation");
    rd(2'd2, m_rem, "R8 remainder after saturation");

    @(posedge clk); @(posedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule